// File: doc/BRIEF.md
# Real-Mode Fetch Address Generator with Reset-Vector Override

This block turns a 16-bit code segment selector and a 16-bit instruction offset into a 32-bit physical fetch address using real-mode segmentation. The selector is moved up four bit places to form a segment base, and the offset is added to that base. It sits between the instruction pointer logic and the fetch path of a core. The selector lives in a register inside the block, which a load strobe writes.

After reset the block does not use the normal translation. It presents the offset with all of the upper sixteen address bits set, so the first fetch goes to the top of the 4 GiB space instead of just below 1 MiB. This override stays in force after reset is released. It ends only when software first writes the code segment selector, which normally happens on the first far jump. A hold input holds back fetch requests, including the first one after reset, and it leaves register initialisation alone.

A decode output comes with each fetch address. It maps the top 64 KiB window onto the legacy 64 KiB window just below 1 MiB, so that boot firmware is reached through either address.

Top module: `rmseg_addr_gen`

## Requirements
- R1: In real mode an accepted fetch returns the address (selector × 16) + offset. This result is 21 bits wide and zero-extended to 32 bits, and a carry into bit 20 is kept with no wrap. For example, selector FFFFh with offset FFFFh gives 0010_FFEFh.
- R2: Synchronous active-high reset sets the selector register to F000h and turns the override on. It also clears fetch_valid, fetch_addr, alias_addr and alias_hit to 0.
- R3: While the override is on, an accepted fetch returns bits 31:16 all ones and bits 15:0 equal to the request's offset. An offset of FFF0h therefore gives FFFF_FFF0h.
- R4: The override stays on after reset is released, whatever fetches happen. The first selector load turns it off and stores the new selector. From then on R1 applies, so selector F000h with offset FFF0h gives 000F_FFF0h.
- R5: When a selector load and an accepted fetch fall in the same cycle, that fetch uses the selector and mode from before the load. The load takes effect from the next fetch.
- R6: A fetch request is accepted only when hold_req is low and rst is low. A request made while hold is high, including during or right after reset, gives no valid fetch and leaves fetch_addr unchanged.
- R7: An accepted request drives fetch_valid high with its address one clock later. In any cycle after a cycle with no accepted request, fetch_valid is low and fetch_addr keeps its last value.
- R8: When fetch_addr bits 31:16 are all ones, alias_hit is 1 and alias_addr is 000F_0000h plus fetch_addr bits 15:0. Both outputs follow fetch_addr in the same cycle.
- R9: For any other fetch_addr, alias_hit is 0 and alias_addr equals fetch_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_load | input | 1 | Writes sel_value into the code selector register |
| sel_value | input | 16 | New code segment selector |
| offset | input | 16 | Instruction offset for this request |
| fetch_req | input | 1 | Fetch address request |
| hold_req | input | 1 | Holds back fetch requests while high |
| fetch_addr | output | 32 | Physical fetch address |
| fetch_valid | output | 1 | fetch_addr belongs to a request accepted in the previous cycle |
| alias_addr | output | 32 | Decoded address after the boot-window alias |
| alias_hit | output | 1 | fetch_addr lies in the top 64 KiB window |

## Verification
The properties assume that reset is asserted for at least one clock before any request. They also assume that sel_value, offset and the strobes are stable over each rising edge, so that a value sampled there can be compared with the registered output one cycle later. The stimulus drives every input on the falling edge and holds reset high for the first cycles, with fetch and hold both active. It then moves through hold, override, same-cycle load and carry cases, and finishes with a stretch of pseudo-random requests, loads and holds. Throughout, a behavioural model in the bench predicts every output on every cycle.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;

    // Translation mode held by the mode controller.
    typedef enum logic {
        MODE_REAL      = 1'b0,
        MODE_RESET_VEC = 1'b1
    } xlate_mode_e;

    // Selector value loaded by reset.
    localparam logic [15:0] RESET_SELECTOR = 16'hF000;

    // Base of the legacy window that the top region maps onto.
    localparam logic [31:0] LEGACY_WINDOW_BASE = 32'h000F_0000;

endpackage

// File: rtl/rmseg_mode_ctl.sv
module rmseg_mode_ctl
    import rmseg_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter logic [SEG_W-1:0] RESET_SEL = SEG_W'(RESET_SELECTOR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_load,
    input  logic [SEG_W-1:0] sel_value,
    output xlate_mode_e      mode_q,
    output logic [SEG_W-1:0] sel_q
);

    typedef struct packed {
        xlate_mode_e      mode;
        logic [SEG_W-1:0] sel;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_load) begin
            st_d.sel  = sel_value;
            st_d.mode = MODE_REAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_RESET_VEC;
            st_q.sel  <= RESET_SEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;
    assign sel_q  = st_q.sel;

endmodule

// File: rtl/rmseg_xlate.sv
module rmseg_xlate
    import rmseg_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 32
) (
    input  xlate_mode_e       mode,
    input  logic [SEG_W-1:0]  sel,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] addr
);

    localparam int BASE_W = SEG_W + SHIFT;
    localparam int LIN_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;
    localparam int HI_W   = ADDR_W - OFF_W;

    logic [LIN_W-1:0]  base_ext;
    logic [LIN_W-1:0]  off_ext;
    logic [LIN_W-1:0]  linear;
    logic [ADDR_W-1:0] real_addr;
    logic [ADDR_W-1:0] vec_addr;

    always_comb begin
        base_ext  = LIN_W'({sel, {SHIFT{1'b0}}});
        off_ext   = LIN_W'(offset);
        linear    = base_ext + off_ext;
        real_addr = ADDR_W'(linear);
        vec_addr  = {{HI_W{1'b1}}, offset};
    end

    generate
        if (HI_W > 0) begin : g_mux
            always_comb begin
                addr = (mode == MODE_RESET_VEC) ? vec_addr : real_addr;
            end
        end else begin : g_flat
            always_comb begin
                addr = real_addr;
            end
        end
    endgenerate

endmodule

// File: rtl/rmseg_alias_dec.sv
module rmseg_alias_dec
    import rmseg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(LEGACY_WINDOW_BASE)
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              hit
);

    always_comb begin
        hit = &addr_in[ADDR_W-1:OFF_W];
        if (hit) begin
            addr_out = {WIN_BASE[ADDR_W-1:OFF_W], addr_in[OFF_W-1:0]};
        end else begin
            addr_out = addr_in;
        end
    end

endmodule

// File: rtl/rmseg_addr_gen.sv
module rmseg_addr_gen
    import rmseg_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_load,
    input  logic [SEG_W-1:0]  sel_value,
    input  logic [OFF_W-1:0]  offset,
    input  logic              fetch_req,
    input  logic              hold_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] alias_addr,
    output logic              alias_hit
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } fetch_st_t;

    xlate_mode_e       mode_q;
    logic [SEG_W-1:0]  sel_q;
    logic [ADDR_W-1:0] xlate_addr;
    logic              accept;
    fetch_st_t         fst_d, fst_q;

    rmseg_mode_ctl #(
        .SEG_W (SEG_W)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .sel_load  (sel_load),
        .sel_value (sel_value),
        .mode_q    (mode_q),
        .sel_q     (sel_q)
    );

    rmseg_xlate #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .SHIFT  (SHIFT),
        .ADDR_W (ADDR_W)
    ) u_xlate (
        .mode   (mode_q),
        .sel    (sel_q),
        .offset (offset),
        .addr   (xlate_addr)
    );

    always_comb begin
        accept      = fetch_req && !hold_req;
        fst_d       = fst_q;
        fst_d.valid = accept;
        if (accept) begin
            fst_d.addr = xlate_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fst_q <= '0;
        end else begin
            fst_q <= fst_d;
        end
    end

    assign fetch_addr  = fst_q.addr;
    assign fetch_valid = fst_q.valid;

    rmseg_alias_dec #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_alias (
        .addr_in  (fst_q.addr),
        .addr_out (alias_addr),
        .hit      (alias_hit)
    );

endmodule

// File: rtl/rmseg_addr_gen_chk.sv
module rmseg_addr_gen_chk
    import rmseg_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_load,
    input logic [SEG_W-1:0]  sel_value,
    input logic [OFF_W-1:0]  offset,
    input logic              fetch_req,
    input logic              hold_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] alias_addr,
    input logic              alias_hit,
    input xlate_mode_e       mode_q,
    input logic [SEG_W-1:0]  sel_q
);

    localparam int LIN_W = (((SEG_W + SHIFT) > OFF_W) ? (SEG_W + SHIFT) : OFF_W) + 1;

    // R1: real-mode results never reach above the 21-bit linear range
    a_r1_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_REAL && fetch_req && !hold_req)
        |=> (fetch_addr[ADDR_W-1:LIN_W] == '0));

    // R3: override output carries all-ones high half and the sampled offset
    a_r3_vector_form: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RESET_VEC && fetch_req && !hold_req)
        |=> ((&fetch_addr[ADDR_W-1:OFF_W]) && fetch_addr[OFF_W-1:0] == $past(offset)));

    // R4: override persists without a load
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RESET_VEC && !sel_load) |=> (mode_q == MODE_RESET_VEC));

    // R4: a load ends the override and stores the selector
    a_r4_load_clears: assert property (@(posedge clk) disable iff (rst)
        sel_load |=> (mode_q == MODE_REAL && sel_q == $past(sel_value)));

    // R6: hold blocks the request
    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        hold_req |=> !fetch_valid);

    // R7: accepted request yields a valid one cycle later
    a_r7_accept: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !hold_req) |=> fetch_valid);

    // R7: address holds when nothing is accepted
    a_r7_addr_holds: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req || hold_req) |=> $stable(fetch_addr));

    // R8: alias hit maps the low half and only for the top window
    a_r8_alias_map: assert property (@(posedge clk) disable iff (rst)
        alias_hit |-> ((&fetch_addr[ADDR_W-1:OFF_W])
                       && alias_addr[OFF_W-1:0] == fetch_addr[OFF_W-1:0]
                       && alias_addr[ADDR_W-1:OFF_W] == LEGACY_WINDOW_BASE[ADDR_W-1:OFF_W]));

    // R9: outside the window the address passes straight through
    a_r9_pass: assert property (@(posedge clk) disable iff (rst)
        !alias_hit |-> (alias_addr == fetch_addr && !(&fetch_addr[ADDR_W-1:OFF_W])));

endmodule

bind rmseg_addr_gen rmseg_addr_gen_chk #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .SHIFT  (SHIFT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_load    (sel_load),
    .sel_value   (sel_value),
    .offset      (offset),
    .fetch_req   (fetch_req),
    .hold_req    (hold_req),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .alias_addr  (alias_addr),
    .alias_hit   (alias_hit),
    .mode_q      (mode_q),
    .sel_q       (sel_q)
);

// File: tb/rmseg_addr_gen_tb.sv
module rmseg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_load;
    logic [15:0] sel_value;
    logic [15:0] offset;
    logic        fetch_req;
    logic        hold_req;
    logic [31:0] fetch_addr;
    logic        fetch_valid;
    logic [31:0] alias_addr;
    logic        alias_hit;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_ovr;
    logic [15:0] m_sel;
    bit          m_valid;
    logic [31:0] m_addr;

    always #5 clk = ~clk;

    rmseg_addr_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .sel_load    (sel_load),
        .sel_value   (sel_value),
        .offset      (offset),
        .fetch_req   (fetch_req),
        .hold_req    (hold_req),
        .fetch_addr  (fetch_addr),
        .fetch_valid (fetch_valid),
        .alias_addr  (alias_addr),
        .alias_hit   (alias_hit)
    );

    function automatic logic [31:0] model_alias(input logic [31:0] a);
        if (a[31:16] == 16'hFFFF) return 32'h000F_0000 + {16'h0, a[15:0]};
        return a;
    endfunction

    task automatic step(input bit r, input bit ld, input logic [15:0] sv,
                        input logic [15:0] off, input bit fr, input bit hr,
                        input string req);
        logic [31:0] exp_alias;
        bit          exp_hit;
        rst = r; sel_load = ld; sel_value = sv; offset = off;
        fetch_req = fr; hold_req = hr;
        // model the coming rising edge
        if (r) begin
            m_ovr = 1; m_sel = 16'hF000; m_valid = 0; m_addr = 0;
        end else begin
            m_valid = fr && !hr;
            if (m_valid) begin
                if (m_ovr) m_addr = {16'hFFFF, off};
                else       m_addr = (32'(m_sel) * 16) + 32'(off);
            end
            if (ld) begin
                m_sel = sv; m_ovr = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        exp_alias = model_alias(m_addr);
        exp_hit   = (m_addr[31:16] == 16'hFFFF);
        vectors++;
        if (fetch_valid !== m_valid || fetch_addr !== m_addr ||
            alias_addr !== exp_alias || alias_hit !== exp_hit) begin
            miscompares++;
            $display("FAIL %s: valid=%0b addr=%08h alias=%08h hit=%0b expected valid=%0b addr=%08h alias=%08h hit=%0b",
                     req, fetch_valid, fetch_addr, alias_addr, alias_hit,
                     m_valid, m_addr, exp_alias, exp_hit);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; sel_load = 0; sel_value = 0; offset = 16'hFFF0;
        fetch_req = 0; hold_req = 0;
        m_ovr = 1; m_sel = 16'hF000; m_valid = 0; m_addr = 0;
        @(negedge clk);
        // R2 reset state, R6 hold and fetch active during reset
        step(1, 0, 16'h0000, 16'hFFF0, 1, 1, "R2");
        step(1, 0, 16'h0000, 16'hFFF0, 1, 1, "R2 R6");
        // R6 hold right after reset
        step(0, 0, 16'h0000, 16'hFFF0, 1, 1, "R6");
        step(0, 0, 16'h0000, 16'hFFF0, 1, 1, "R6");
        // R3 first fetch goes to the top vector, R8 aliases it
        step(0, 0, 16'h0000, 16'hFFF0, 1, 0, "R3 R8");
        for (int i = 1; i < 5; i++)
            step(0, 0, 16'h0000, 16'hFFF0 + 16'(i), 1, 0, "R3");
        // R7 idle cycle keeps address
        step(0, 0, 16'h0000, 16'h0000, 0, 0, "R7");
        step(0, 0, 16'h0000, 16'h1234, 1, 0, "R4 R8");
        step(0, 0, 16'h0000, 16'h0000, 1, 1, "R6 R7");
        // R5 load with fetch uses old mode
        step(0, 1, 16'hF000, 16'hFFF8, 1, 0, "R5");
        // R4 now real mode, R9 pass-through
        step(0, 0, 16'h0000, 16'hFFF0, 1, 0, "R4 R9");
        // R5 load of new selector with fetch uses old selector
        step(0, 1, 16'h1234, 16'h0010, 1, 0, "R5");
        step(0, 0, 16'h0000, 16'h0010, 1, 0, "R1");
        // R1 carry into bit 20
        step(0, 1, 16'hFFFF, 16'h0000, 0, 0, "R1");
        step(0, 0, 16'h0000, 16'hFFFF, 1, 0, "R1");
        step(0, 1, 16'h0000, 16'h0000, 0, 0, "R1");
        step(0, 0, 16'h0000, 16'h0000, 1, 0, "R1");
        step(0, 0, 16'h0000, 16'hABCD, 1, 1, "R6");
        // R2 reset again restores override
        step(1, 0, 16'h0000, 16'h0000, 0, 0, "R2");
        step(0, 0, 16'h0000, 16'hFFF0, 1, 0, "R2 R3");
        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step((rv[7:0] == 8'h00), (rv[4:2] == 3'b000), rv[31:16],
                 rv[23:8], rv[0] | rv[1], (rv[6:5] == 2'b11), "R1 R3 R4 R5 R6 R7 R8 R9");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule